// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets software on any processor ring numbered doorbells on one or more target processors. One global trigger write carries both a doorbell number and a bitmap of target processors. Every target selected in the bitmap records that doorbell in its own pending (cause) register, and the bits accumulate until software clears them.

Each processor also owns a doorbell enable register and a single gate bit. The gate decides whether that processor's doorbell summary reaches it as interrupt identifier 0. The summary is a level. It stays high while any pending doorbell on that processor is also enabled. Software clears pending doorbells by writing the cause register. A zero bit in the written value clears the matching pending bit, and a one bit keeps it. Writing all zeros therefore clears everything. If a trigger and a clear hit the same bit in the same cycle, the trigger wins, so no event is lost.

The per-processor registers are reached through one configuration write port and one combinational read port. Both ports select a processor and a register by number.

Top module: `dbell_unit`

## Requirements
- R1: After synchronous active-low reset, every cause bit and every enable bit is 0, every gate bit is 1 (masked), and `bell_pending` and `bell_irq` are all 0.
- R2: A trigger write whose number field `trig_data[4:0]` holds n < NUM_BELLS sets cause bit n on each processor c whose bit `trig_data[8+c]` is 1. The bit is visible from the next clock edge. Other cause bits and unselected processors keep their values.
- R3: A trigger whose number field holds a value of NUM_BELLS or more changes no cause register.
- R4: A configuration write with select 0 (cause) to processor c replaces its cause with cause AND wdata. Writing zero clears all pending doorbells.
- R5: When a trigger and a cause write reach the same processor in the same cycle, the trigger's bit is set after the edge, whatever value the clear wrote.
- R6: A configuration write with select 1 (enable) loads wdata into that processor's enable register, and select 1 reads it back.
- R7: `bell_pending[c]` is 1 exactly while cause AND enable of processor c is non-zero.
- R8: A configuration write with select 2 loads wdata bit 0 into the gate of processor c, where 1 means masked. `bell_irq[c]` equals `bell_pending[c]` while the gate is 0, and is 0 while the gate is 1. Select 2 reads the gate in bit 0 and zeros above.
- R9: A configuration write changes only the selected processor's registers. Select 3 writes nothing and reads as zero.
- R10: Trigger bitmap bits at or above position 8+NUM_CPU, and number-field bits, never reach processors that are not selected. A trigger with an empty bitmap has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_we | input | 1 | Global trigger write strobe |
| trig_data | input | DATA_W | Doorbell number in [4:0], target bitmap from bit 8 |
| cfg_we | input | 1 | Per-processor register write strobe |
| cfg_cpu | input | CPU_W | Processor addressed by the write |
| cfg_sel | input | 2 | Register select: 0 cause, 1 enable, 2 gate, 3 unused |
| cfg_wdata | input | NUM_BELLS | Write data |
| rd_cpu | input | CPU_W | Processor addressed by the read |
| rd_sel | input | 2 | Register select for the read, same codes |
| rd_data | output | NUM_BELLS | Combinational read data |
| bell_pending | output | NUM_CPU | Per-processor doorbell summary level |
| bell_irq | output | NUM_CPU | Per-processor summary after the identifier-0 gate |

## Verification
A cause bit that is lost, stuck, or set on the wrong processor shows on the read port in the first cycle after the trigger or clear. When that bit is enabled, it also shows on `bell_pending` in the same cycle. A corrupted enable or gate shows at once as a wrong summary or interrupt level on the affected processor. The bench therefore compares every register of every processor, and both outputs, after each single operation. Any wrong internal state is caught within one cycle of the write that produced it.

// File: rtl/dbell_pkg.sv
// Shared definitions for the doorbell unit.
package dbell_pkg;

    // Register select codes on the configuration and read ports.
    typedef enum logic [1:0] {
        SEL_CAUSE  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GATE   = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dbell_trig_decode.sv
// Trigger decoder.
// Turns one global trigger write into a per-processor, per-doorbell raise
// matrix.
// Assumes: MAP_LSB + NUM_CPU <= DATA_W and NUM_BELLS <= 2**NUM_FIELD_W.
// Numbers at or above NUM_BELLS match no column, so they raise nothing.
module dbell_trig_decode #(
    parameter int NUM_CPU     = 4,
    parameter int NUM_BELLS   = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_FIELD_W = 5,
    parameter int MAP_LSB     = 8
) (
    input  logic                                trig_we,
    input  logic [DATA_W-1:0]                   trig_data,
    output logic [NUM_CPU-1:0][NUM_BELLS-1:0]   raise
);

    logic [NUM_FIELD_W-1:0] bell_num;
    logic [NUM_BELLS-1:0]   bell_hot;

    // Extract the doorbell number field.
    always_comb bell_num = trig_data[NUM_FIELD_W-1:0];

    // One-hot doorbell column, empty for numbers beyond the active range.
    generate
        for (genvar b = 0; b < NUM_BELLS; b++) begin : g_bell
            always_comb bell_hot[b] = trig_we && (bell_num == NUM_FIELD_W'(b));
        end
    endgenerate

    // Fan the column out to the processors selected in the bitmap.
    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            always_comb raise[c] = trig_data[MAP_LSB + c] ? bell_hot : '0;
        end
    endgenerate

endmodule

// File: rtl/dbell_cpu_bank.sv
// Per-processor doorbell state.
// Holds the cause, enable and gate registers of one processor and forms its
// summary and interrupt outputs.
// Assumes: the configuration strobes are already qualified for this processor.
// A raise in the same cycle as a cause write overrides the clear.
module dbell_cpu_bank #(
    parameter int NUM_BELLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BELLS-1:0] raise,
    input  logic                 wr_cause,
    input  logic                 wr_enable,
    input  logic                 wr_gate,
    input  logic [NUM_BELLS-1:0] wdata,
    output logic [NUM_BELLS-1:0] cause_q,
    output logic [NUM_BELLS-1:0] enable_q,
    output logic                 gate_q,
    output logic                 pending,
    output logic                 irq
);

    logic [NUM_BELLS-1:0] cause_kept;

    // Bits that survive this cycle's clearing write.
    always_comb cause_kept = wr_cause ? (cause_q & wdata) : cause_q;

    // Cause register: new raises OR on top of the surviving bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_kept | raise;
    end

    // Enable register: loaded whole by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_enable) enable_q <= wdata;
    end

    // Identifier-0 gate: resets masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= 1'b1;
        else if (wr_gate) gate_q <= wdata[0];
    end

    // Level summary of enabled pending doorbells.
    always_comb pending = |(cause_q & enable_q);

    // Summary presented as identifier 0 unless gated off.
    always_comb irq = pending && !gate_q;

endmodule

// File: rtl/dbell_read_mux.sv
// Read-back multiplexer.
// Selects one register of one processor for the combinational read port.
// Assumes: a processor index at or above NUM_CPU reads as zero.
module dbell_read_mux
    import dbell_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int NUM_BELLS = 8,
    parameter int CPU_W     = 2
) (
    input  logic [NUM_CPU-1:0][NUM_BELLS-1:0] cause_bus,
    input  logic [NUM_CPU-1:0][NUM_BELLS-1:0] enable_bus,
    input  logic [NUM_CPU-1:0]                gate_bus,
    input  logic [CPU_W-1:0]                  rd_cpu,
    input  logic [1:0]                        rd_sel,
    output logic [NUM_BELLS-1:0]              rd_data
);

    logic [NUM_BELLS-1:0] cause_pick;
    logic [NUM_BELLS-1:0] enable_pick;
    logic                 gate_pick;

    // Pick the addressed processor's registers.
    always_comb begin
        cause_pick  = '0;
        enable_pick = '0;
        gate_pick   = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (rd_cpu == CPU_W'(c)) begin
                cause_pick  = cause_bus[c];
                enable_pick = enable_bus[c];
                gate_pick   = gate_bus[c];
            end
        end
    end

    // Pick the register by select code.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CAUSE:  rd_data = cause_pick;
            SEL_ENABLE: rd_data = enable_pick;
            SEL_GATE:   rd_data = {{(NUM_BELLS-1){1'b0}}, gate_pick};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dbell_unit.sv
// Inter-processor doorbell unit, top level.
// Decodes global triggers, keeps per-processor cause, enable and gate state,
// and drives the per-processor summary and interrupt levels.
// Assumes: one trigger and one configuration write per cycle at most.
module dbell_unit
    import dbell_pkg::*;
#(
    parameter int NUM_CPU     = 4,
    parameter int NUM_BELLS   = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_FIELD_W = 5,
    parameter int MAP_LSB     = 8,
    localparam int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_we,
    input  logic [DATA_W-1:0]    trig_data,
    input  logic                 cfg_we,
    input  logic [CPU_W-1:0]     cfg_cpu,
    input  logic [1:0]           cfg_sel,
    input  logic [NUM_BELLS-1:0] cfg_wdata,
    input  logic [CPU_W-1:0]     rd_cpu,
    input  logic [1:0]           rd_sel,
    output logic [NUM_BELLS-1:0] rd_data,
    output logic [NUM_CPU-1:0]   bell_pending,
    output logic [NUM_CPU-1:0]   bell_irq
);

    logic [NUM_CPU-1:0][NUM_BELLS-1:0] raise_bus;
    logic [NUM_CPU-1:0][NUM_BELLS-1:0] cause_bus;
    logic [NUM_CPU-1:0][NUM_BELLS-1:0] enable_bus;
    logic [NUM_CPU-1:0]                gate_bus;

    dbell_trig_decode #(
        .NUM_CPU     (NUM_CPU),
        .NUM_BELLS   (NUM_BELLS),
        .DATA_W      (DATA_W),
        .NUM_FIELD_W (NUM_FIELD_W),
        .MAP_LSB     (MAP_LSB)
    ) u_decode (
        .trig_we   (trig_we),
        .trig_data (trig_data),
        .raise     (raise_bus)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
            logic hit;
            logic wr_cause;
            logic wr_enable;
            logic wr_gate;

            // Qualify the configuration write for this processor.
            always_comb begin
                hit       = cfg_we && (cfg_cpu == CPU_W'(c));
                wr_cause  = hit && (reg_sel_e'(cfg_sel) == SEL_CAUSE);
                wr_enable = hit && (reg_sel_e'(cfg_sel) == SEL_ENABLE);
                wr_gate   = hit && (reg_sel_e'(cfg_sel) == SEL_GATE);
            end

            dbell_cpu_bank #(
                .NUM_BELLS (NUM_BELLS)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .raise     (raise_bus[c]),
                .wr_cause  (wr_cause),
                .wr_enable (wr_enable),
                .wr_gate   (wr_gate),
                .wdata     (cfg_wdata),
                .cause_q   (cause_bus[c]),
                .enable_q  (enable_bus[c]),
                .gate_q    (gate_bus[c]),
                .pending   (bell_pending[c]),
                .irq       (bell_irq[c])
            );
        end
    endgenerate

    dbell_read_mux #(
        .NUM_CPU   (NUM_CPU),
        .NUM_BELLS (NUM_BELLS),
        .CPU_W     (CPU_W)
    ) u_rdmux (
        .cause_bus  (cause_bus),
        .enable_bus (enable_bus),
        .gate_bus   (gate_bus),
        .rd_cpu     (rd_cpu),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/dbell_unit_chk.sv
// Protocol checker for the doorbell unit, bound to every instance.
// Observes top-level ports and the per-processor cause and enable buses.
module dbell_unit_chk #(
    parameter int NUM_CPU     = 4,
    parameter int NUM_BELLS   = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_FIELD_W = 5,
    parameter int MAP_LSB     = 8,
    parameter int CPU_W       = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                trig_we,
    input logic [DATA_W-1:0]                   trig_data,
    input logic                                cfg_we,
    input logic [CPU_W-1:0]                    cfg_cpu,
    input logic [1:0]                          cfg_sel,
    input logic [NUM_BELLS-1:0]                cfg_wdata,
    input logic [NUM_CPU-1:0][NUM_BELLS-1:0]   cause_bus,
    input logic [NUM_CPU-1:0][NUM_BELLS-1:0]   enable_bus,
    input logic [NUM_CPU-1:0]                  bell_pending,
    input logic [NUM_CPU-1:0]                  bell_irq
);

    logic [NUM_FIELD_W-1:0] num_f;
    logic [NUM_BELLS-1:0]   want_bit;

    // Expected one-hot doorbell of the current trigger.
    always_comb begin
        num_f    = trig_data[NUM_FIELD_W-1:0];
        want_bit = (int'(num_f) < NUM_BELLS) ? (NUM_BELLS'(1) << num_f) : '0;
    end

    AST_IRQ_WITHIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_irq & ~bell_pending) == '0); // R8

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bell_pending == '0) && (bell_irq == '0)); // R1

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
            AST_TRIG_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                trig_we && trig_data[MAP_LSB + c]
                |=> (cause_bus[c] & $past(want_bit)) == $past(want_bit)); // R5

            AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we && (cfg_cpu == CPU_W'(c)) && (cfg_sel == 2'd0) && !trig_we
                |=> (cause_bus[c] & ~$past(cfg_wdata)) == '0); // R4

            AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !trig_we && !(cfg_we && (cfg_cpu == CPU_W'(c)) && (cfg_sel == 2'd0))
                |=> $stable(cause_bus[c])); // R9

            AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we && (cfg_cpu == CPU_W'(c)) && (cfg_sel == 2'd1)
                |=> enable_bus[c] == $past(cfg_wdata)); // R6
        end
    endgenerate

endmodule

bind dbell_unit dbell_unit_chk #(
    .NUM_CPU     (NUM_CPU),
    .NUM_BELLS   (NUM_BELLS),
    .DATA_W      (DATA_W),
    .NUM_FIELD_W (NUM_FIELD_W),
    .MAP_LSB     (MAP_LSB),
    .CPU_W       (CPU_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_we      (trig_we),
    .trig_data    (trig_data),
    .cfg_we       (cfg_we),
    .cfg_cpu      (cfg_cpu),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cause_bus    (cause_bus),
    .enable_bus   (enable_bus),
    .bell_pending (bell_pending),
    .bell_irq     (bell_irq)
);

// File: tb/dbell_unit_test.sv
`timescale 1ns/100ps
// Self-checking bench for the doorbell unit.
// Uses four processors and eight doorbells.
module dbell_unit_test;

    localparam int NC = 4;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_we = 1'b0;
    logic [31:0]   trig_data = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_cpu = '0;
    logic [1:0]    cfg_sel = '0;
    logic [NB-1:0] cfg_wdata = '0;
    logic [1:0]    rd_cpu = '0;
    logic [1:0]    rd_sel = '0;
    logic [NB-1:0] rd_data;
    logic [NC-1:0] bell_pending;
    logic [NC-1:0] bell_irq;

    int total = 0;
    int bad = 0;

    logic [NB-1:0] m_cause [NC];
    logic [NB-1:0] m_en    [NC];
    logic          m_gate  [NC];

    always #2 clk = ~clk;

    dbell_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_we      (trig_we),
        .trig_data    (trig_data),
        .cfg_we       (cfg_we),
        .cfg_cpu      (cfg_cpu),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .rd_cpu       (rd_cpu),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .bell_pending (bell_pending),
        .bell_irq     (bell_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every register of every processor and both outputs with the model.
    task automatic check_all(string tag);
        for (int c = 0; c < NC; c++) begin
            for (int s = 0; s < 4; s++) begin
                logic [NB-1:0] e;
                rd_cpu = 2'(c);
                rd_sel = 2'(s);
                #0.1;
                case (s)
                    0: e = m_cause[c];
                    1: e = m_en[c];
                    2: e = {7'b0, m_gate[c]};
                    default: e = '0;
                endcase
                check(s == 3 ? "R9" : tag, 32'(rd_data), 32'(e), $sformatf("cpu%0d sel%0d", c, s));
            end
            check("R7", 32'(bell_pending[c]), 32'(|(m_cause[c] & m_en[c])), $sformatf("pending cpu%0d", c));
            check("R8", 32'(bell_irq[c]), 32'((|(m_cause[c] & m_en[c])) & ~m_gate[c]), $sformatf("irq cpu%0d", c));
        end
    endtask

    // One cycle with an optional trigger and an optional configuration write.
    task automatic apply(bit t_we, logic [31:0] t_d, bit c_we, int cpu, int sel,
                         logic [NB-1:0] wd, string tag);
        @(negedge clk);
        trig_we = t_we; trig_data = t_d;
        cfg_we = c_we; cfg_cpu = 2'(cpu); cfg_sel = 2'(sel); cfg_wdata = wd;
        if (c_we) begin
            case (sel)
                0: m_cause[cpu] = m_cause[cpu] & wd;
                1: m_en[cpu] = wd;
                2: m_gate[cpu] = wd[0];
                default: ;
            endcase
        end
        if (t_we && t_d[4:0] < NB) begin
            for (int c = 0; c < NC; c++)
                if (t_d[8 + c]) m_cause[c][t_d[4:0]] = 1'b1;
        end
        @(negedge clk);
        trig_we = 1'b0; cfg_we = 1'b0;
        check_all(tag);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_cause[c] = '0; m_en[c] = '0; m_gate[c] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // Enables and gates for the trigger sweep; cpu3 stays gated.
        apply(0, 0, 1, 0, 1, 8'hA5, "R6");
        apply(0, 0, 1, 1, 1, 8'h5A, "R6");
        apply(0, 0, 1, 2, 1, 8'hFF, "R6");
        apply(0, 0, 1, 3, 1, 8'h0F, "R6");
        for (int c = 0; c < 3; c++) apply(0, 0, 1, c, 2, 8'h00, "R8");

        // Every bitmap against every number, with junk above the bitmap.
        for (int map = 0; map < 16; map++) begin
            for (int n = 0; n < 32; n++) begin
                logic [31:0] d;
                d = (32'((map * 5 + n) & 15) << 12) | (32'(map) << 8) | 32'(n);
                apply(1, d, 0, 0, 0, '0, n < NB ? (map == 0 ? "R10" : "R2") : "R3");
                if ((n & 3) == 3)
                    for (int c = 0; c < NC; c++) apply(0, 0, 1, c, 0, 8'h00, "R4");
            end
        end

        // Partial clears keep the one bits.
        apply(1, 32'h0F07, 0, 0, 0, '0, "R2");
        apply(1, 32'h0F02, 0, 0, 0, '0, "R2");
        apply(0, 0, 1, 1, 0, 8'h80, "R4");
        apply(0, 0, 1, 2, 0, 8'h04, "R4");

        // Trigger and clear on the same bit and processor in one cycle.
        apply(1, 32'h0203, 1, 1, 0, 8'h00, "R5");
        apply(1, 32'h0406, 1, 2, 0, 8'hF0, "R5");

        // Unused select writes nothing; gate toggles on a pending processor.
        apply(0, 0, 1, 2, 3, 8'hFF, "R9");
        apply(0, 0, 1, 2, 2, 8'h01, "R8");
        apply(0, 0, 1, 2, 2, 8'h00, "R8");

        // Enable sweep on cpu0 with pending bits present.
        apply(1, 32'h0104, 0, 0, 0, '0, "R2");
        for (int v = 0; v < 256; v++) apply(0, 0, 1, 0, 1, 8'(v), "R6");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule